// File: doc/BRIEF.md
# Tick-Timed Line Glitch Filter

This block cleans up an asynchronous single-wire bus input before it reaches a protocol decoder. The raw pin is first brought into the system clock domain by a two-flop synchroniser. A new level then reaches the output only after it has held for a programmable number of filter ticks. The output starts high, which is the idle level of an open-drain line.

The rejection window is set by two fields: a 2-bit timebase select and a 3-bit delay. The required hold time is delay × 3 ticks of the selected timebase. The tick strobes come from a prescaler that runs on the system clock. With the default parameters they repeat every 3, 24, 240 and 2400 clock cycles, which is 125 ns, 1 µs, 10 µs and 100 µs at a 24 MHz clock. The usual operating point is the 1 µs tick with a delay of 7.

A delay of zero turns the filter off, so the synchronised level passes straight through. A soft reset holds the block in its idle state. When the enable is low, the output is frozen. Single-cycle rise and fall strobes mark each accepted level change.

Top module: `glitch_filter_tick`

## Requirements
- R1: While rst_n is low, line_flt is 1 and rise_pulse and fall_pulse are 0.
- R2: The raw input passes through two synchroniser flops. With delay = 0, a level change on line_raw that is stable across clock edge k appears on line_flt, with its strobe, exactly after edge k+3.
- R3: delay = 0 disables filtering: every synchronised change, including a one-cycle pulse, is forwarded.
- R4: With delay D > 0 and tick period P cycles, a changed level that lasts no more than (3·D−1)·P cycles never reaches line_flt.
- R5: A changed level held for at least 3·D·P cycles is accepted. Its strobe appears after an edge in the window [k+3+(3·D−1)·P, k+2+3·D·P], where k is the last edge before the change.
- R6: The tick count restarts whenever the synchronised input returns to the current output level. Separate short excursions never add up to an acceptance.
- R7: tick_sel encodes the timebase as follows: 0 gives a tick every BASE_DIV cycles (3), 1 every US_DIV cycles (24), 2 every 10·US_DIV cycles (240) and 3 every 100·US_DIV cycles (2400).
- R8: rise_pulse is high for exactly one cycle when line_flt goes 0→1, and fall_pulse when it goes 1→0. The strobe appears in the same cycle as the new level, and the two strobes are never high together.
- R9: While enable is low, line_flt holds its value, both strobes stay 0, and changes on line_raw have no effect.
- R10: While soft_rst is high, line_flt is 1 and no strobe is produced. After soft_rst is released, the synchronised input is filtered again starting from the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous hold-in-reset, 1 = reset |
| enable | input | 1 | Filter enable; 0 freezes the output |
| tick_sel | input | 2 | Timebase select (see R7) |
| delay | input | 3 | Hold length in units of three ticks; 0 = bypass |
| line_raw | input | 1 | Asynchronous raw line |
| line_flt | output | 1 | Filtered line level |
| rise_pulse | output | 1 | One-cycle strobe on an accepted 0→1 change |
| fall_pulse | output | 1 | One-cycle strobe on an accepted 1→0 change |

## Verification
The hardest case to reach is the counter restart. It needs two excursions, each just below the threshold, separated by a return lasting only a couple of cycles. Their combined length must exceed the threshold, so that a filter which failed to clear its count would accept the second one. The stimulus reaches this by timing each excursion at (3·D−1)·P cycles with a two-cycle gap. Because the prescaler phase is unknown, acceptance is checked against a window one tick wide rather than a single cycle. The slowest timebase gets its own run so that it is covered as well.

// File: rtl/glitch_flt_pkg.sv
package glitch_flt_pkg;

    localparam int DLY_W     = 3;
    localparam int SEL_W     = 2;
    localparam int FILT_MULT = 3;
    localparam int CNT_W     = DLY_W + 2;

    typedef enum logic [SEL_W-1:0] {
        TB_BASE  = 2'd0,
        TB_1US   = 2'd1,
        TB_10US  = 2'd2,
        TB_100US = 2'd3
    } timebase_e;

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
        logic             rise;
        logic             fall;
    } flt_state_t;

endpackage

// File: rtl/glitch_flt_sync.sv
module glitch_flt_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        if (clr) begin
            chain_d = {STAGES{RESET_VAL}};
        end else begin
            chain_d = {chain_q[STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/glitch_flt_tickgen.sv
module glitch_flt_tickgen #(
    parameter int BASE_DIV  = 3,
    parameter int US_DIV    = 24,
    parameter int DECADES   = 2,
    parameter int DEC_RATIO = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    output logic [DECADES+1:0]   ticks
);

    localparam int BASE_W = $clog2(BASE_DIV + 1);
    localparam int US_W   = $clog2(US_DIV + 1);
    localparam int DEC_W  = $clog2(DEC_RATIO + 1);

    logic [BASE_W-1:0] base_d, base_q;
    logic [US_W-1:0]   us_d, us_q;

    // fast timebase and microsecond timebase run side by side from the clock
    always_comb begin
        if (clr || base_q == BASE_W'(BASE_DIV - 1)) begin
            base_d = '0;
        end else begin
            base_d = base_q + 1'b1;
        end
        if (clr || us_q == US_W'(US_DIV - 1)) begin
            us_d = '0;
        end else begin
            us_d = us_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            us_q   <= '0;
        end else begin
            base_q <= base_d;
            us_q   <= us_d;
        end
    end

    assign ticks[0] = !clr && (base_q == BASE_W'(BASE_DIV - 1));
    assign ticks[1] = !clr && (us_q == US_W'(US_DIV - 1));

    // each decade stage divides the strobe of the stage below by DEC_RATIO
    for (genvar g = 0; g < DECADES; g++) begin : g_decade
        logic [DEC_W-1:0] dcnt_d, dcnt_q;

        always_comb begin
            dcnt_d = dcnt_q;
            if (clr) begin
                dcnt_d = '0;
            end else if (ticks[g+1]) begin
                if (dcnt_q == DEC_W'(DEC_RATIO - 1)) begin
                    dcnt_d = '0;
                end else begin
                    dcnt_d = dcnt_q + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dcnt_q <= '0;
            end else begin
                dcnt_q <= dcnt_d;
            end
        end

        assign ticks[g+2] = ticks[g+1] && (dcnt_q == DEC_W'(DEC_RATIO - 1));
    end

endmodule

// File: rtl/glitch_flt_core.sv
module glitch_flt_core
    import glitch_flt_pkg::*;
#(
    parameter int NUM_TICKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 enable,
    input  logic [SEL_W-1:0]     tick_sel,
    input  logic [DLY_W-1:0]     delay,
    input  logic [NUM_TICKS-1:0] ticks,
    input  logic                 sync_lvl,
    output logic                 lvl,
    output logic                 rise,
    output logic                 fall
);

    localparam logic [CNT_W-1:0] MULT_C = CNT_W'(FILT_MULT);

    flt_state_t st_d, st_q;
    logic             tick;
    logic [CNT_W-1:0] thr;
    logic             accept;

    assign tick = ticks[tick_sel];
    assign thr  = CNT_W'(delay) * MULT_C;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        accept    = 1'b0;
        if (soft_rst) begin
            st_d.lvl = 1'b1;
            st_d.cnt = '0;
        end else if (!enable) begin
            st_d.cnt = '0;
        end else if (sync_lvl == st_q.lvl) begin
            // input returned to the filtered level: restart the window
            st_d.cnt = '0;
        end else if (delay == '0) begin
            accept = 1'b1;
        end else if (tick) begin
            if (st_q.cnt == thr - 1'b1) begin
                accept = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (accept) begin
            st_d.lvl  = sync_lvl;
            st_d.cnt  = '0;
            st_d.rise = sync_lvl;
            st_d.fall = !sync_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: 1'b1, cnt: '0, rise: 1'b0, fall: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl  = st_q.lvl;
    assign rise = st_q.rise;
    assign fall = st_q.fall;

endmodule

// File: rtl/glitch_filter_tick.sv
module glitch_filter_tick
    import glitch_flt_pkg::*;
#(
    parameter int BASE_DIV    = 3,
    parameter int US_DIV      = 24,
    parameter int DECADES     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             enable,
    input  logic [SEL_W-1:0] tick_sel,
    input  logic [DLY_W-1:0] delay,
    input  logic             line_raw,
    output logic             line_flt,
    output logic             rise_pulse,
    output logic             fall_pulse
);

    localparam int NUM_TICKS = DECADES + 2;

    logic                 sync_lvl;
    logic [NUM_TICKS-1:0] ticks;

    glitch_flt_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .din   (line_raw),
        .dout  (sync_lvl)
    );

    glitch_flt_tickgen #(
        .BASE_DIV  (BASE_DIV),
        .US_DIV    (US_DIV),
        .DECADES   (DECADES),
        .DEC_RATIO (10)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .ticks (ticks)
    );

    glitch_flt_core #(
        .NUM_TICKS (NUM_TICKS)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .enable   (enable),
        .tick_sel (tick_sel),
        .delay    (delay),
        .ticks    (ticks),
        .sync_lvl (sync_lvl),
        .lvl      (line_flt),
        .rise     (rise_pulse),
        .fall     (fall_pulse)
    );

endmodule

// File: rtl/glitch_filter_tick_chk.sv
module glitch_filter_tick_chk
    import glitch_flt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             enable,
    input logic [DLY_W-1:0] delay,
    input logic             sync_lvl,
    input logic             line_flt,
    input logic             rise_pulse,
    input logic             fall_pulse
);

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_pulse && fall_pulse));

    assert_rise_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> (line_flt && !$past(line_flt)));

    assert_fall_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |-> (!line_flt && $past(line_flt)));

    assert_change_strobed_R8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (!$past(soft_rst) && (line_flt != $past(line_flt))) |-> (rise_pulse || fall_pulse));

    assert_soft_rst_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (line_flt && !rise_pulse && !fall_pulse));

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !soft_rst) |=> $stable(line_flt));

    assert_quiet_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rise_pulse && !fall_pulse));

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (delay == '0 && enable && !soft_rst) |=> (line_flt == $past(sync_lvl)));

endmodule

bind glitch_filter_tick glitch_filter_tick_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .enable     (enable),
    .delay      (delay),
    .sync_lvl   (sync_lvl),
    .line_flt   (line_flt),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse)
);

// File: tb/glitch_filter_tick_bench.sv
module glitch_filter_tick_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BASE_DIV   = 3;
    localparam int US_DIV     = 24;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       enable = 1'b1;
    logic [1:0] tick_sel = 2'd0;
    logic [2:0] delay = 3'd0;
    logic       line_raw = 1'b1;
    logic       line_flt, rise_pulse, fall_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_k = 0;
    bit done = 0;

    bit    lvl_q[$];
    int    lo_q[$];
    int    hi_q[$];
    string tag_q[$];

    glitch_filter_tick u_glitch_filter_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .enable     (enable),
        .tick_sel   (tick_sel),
        .delay      (delay),
        .line_raw   (line_raw),
        .line_flt   (line_flt),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int tick_period(input int sel);
        case (sel)
            0: return BASE_DIV;
            1: return US_DIV;
            2: return US_DIV * 10;
            default: return US_DIV * 100;
        endcase
    endfunction

    task automatic set_level(input bit v);
        @(negedge clk);
        line_raw = v;
        last_k = cyc;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input bit v, input int lo, input int hi, input string tag);
        lvl_q.push_back(v);
        lo_q.push_back(lo);
        hi_q.push_back(hi);
        tag_q.push_back(tag);
    endtask

    // drive a level that must be accepted by the filter at its current settings
    task automatic drive_accept(input bit v, input string tag);
        int p, thr;
        p   = tick_period(int'(tick_sel));
        thr = 3 * int'(delay);
        set_level(v);
        if (delay == 0) push(v, last_k + 3, last_k + 3, tag);
        else push(v, last_k + 3 + (thr - 1) * p, last_k + 2 + thr * p, tag);
        hold((thr == 0) ? 6 : thr * p + 10);
    endtask

    task automatic drained(input string tag);
        chk(lvl_q.size() == 0, tag, lvl_q.size(), 0);
    endtask

    // monitor: every strobe must match the next expected change and its window
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (rise_pulse || fall_pulse)) begin
                chk(!(rise_pulse && fall_pulse), "R8 both strobes", 1, 0);
                if (lvl_q.size() == 0) begin
                    chk(1'b0, "R4/R6/R9 unexpected strobe", int'(rise_pulse), 0);
                end else begin
                    bit    ev;
                    int    lo, hi;
                    string tg;
                    ev = lvl_q.pop_front();
                    lo = lo_q.pop_front();
                    hi = hi_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(rise_pulse == ev, {tg, " R8 strobe kind"}, int'(rise_pulse), int'(ev));
                    chk(line_flt == ev, {tg, " R8 level with strobe"}, int'(line_flt), int'(ev));
                    chk(cyc >= lo && cyc <= hi, {tg, " timing"}, cyc, lo);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        hold(3);
        chk(line_flt == 1'b1, "R1 line_flt in reset", int'(line_flt), 1);
        chk(!rise_pulse && !fall_pulse, "R1 strobes in reset", int'(rise_pulse | fall_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
        hold(4);
        chk(line_flt == 1'b1, "R1 line_flt after reset", int'(line_flt), 1);

        // R2 / R3: bypass with exact three-edge latency, single-cycle pulse forwarded
        delay = 3'd0;
        drive_accept(1'b0, "R2 fall");
        drive_accept(1'b1, "R2 rise");
        set_level(1'b0);
        push(1'b0, last_k + 3, last_k + 3, "R3 pulse fall");
        set_level(1'b1);
        push(1'b1, last_k + 3, last_k + 3, "R3 pulse rise");
        hold(8);
        drained("R3 drained");
        chk(line_flt == 1'b1, "R3 level", int'(line_flt), 1);

        // R4 / R5: 1 us tick, delay 7 -> 21 ticks
        tick_sel = 2'd1;
        delay    = 3'd7;
        hold(2);
        set_level(1'b0);
        hold(20 * 24 - 1);
        set_level(1'b1);
        hold(600);
        chk(line_flt == 1'b1, "R4 glitch rejected", int'(line_flt), 1);
        drained("R4 no strobe");
        drive_accept(1'b0, "R5 fall");
        chk(line_flt == 1'b0, "R5 low accepted", int'(line_flt), 0);
        drive_accept(1'b1, "R5 rise");
        drained("R5 drained");

        // R6: two sub-threshold excursions with a short return, delay 2 -> 6 ticks
        delay = 3'd2;
        hold(2);
        set_level(1'b0);
        hold(5 * 24 - 1);
        set_level(1'b1);
        hold(1);
        set_level(1'b0);
        hold(5 * 24 - 1);
        set_level(1'b1);
        hold(6 * 24 * 3);
        chk(line_flt == 1'b1, "R6 restart prevents accumulation", int'(line_flt), 1);
        drained("R6 no strobe");

        // R7: every timebase with delay 1 -> 3 ticks
        delay = 3'd1;
        for (int s = 0; s < 4; s++) begin
            tick_sel = 2'(s);
            hold(2);
            drive_accept(1'b0, $sformatf("R7 sel%0d fall", s));
            drive_accept(1'b1, $sformatf("R7 sel%0d rise", s));
            drained($sformatf("R7 sel%0d drained", s));
        end

        // R9: enable low freezes output
        delay = 3'd0;
        tick_sel = 2'd0;
        @(negedge clk);
        enable = 1'b0;
        set_level(1'b0);
        hold(10);
        chk(line_flt == 1'b1, "R9 frozen while disabled", int'(line_flt), 1);
        set_level(1'b1);
        hold(5);
        enable = 1'b1;
        hold(6);
        chk(line_flt == 1'b1, "R9 level after re-enable", int'(line_flt), 1);
        drained("R9 no strobe");

        // R10: soft reset forces idle, then filtering resumes
        drive_accept(1'b0, "R10 pre fall");
        @(negedge clk);
        soft_rst = 1'b1;
        hold(4);
        chk(line_flt == 1'b1, "R10 idle in soft reset", int'(line_flt), 1);
        @(negedge clk);
        soft_rst = 1'b0;
        push(1'b0, cyc + 3, cyc + 3, "R10 refilter fall");
        hold(8);
        chk(line_flt == 1'b0, "R10 level after release", int'(line_flt), 0);
        drive_accept(1'b1, "R10 rise");
        drained("R10 drained");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule